// File: doc/BRIEF.md
# Three-Bank Clock Divider with Coincidence Marker

This block takes one fast source clock and produces three banks of divided clock outputs, A, B and C. Each bank has a fixed menu of four even divisors, picked by its own 2-bit code. A global post-divide input doubles every divisor at once. All outputs have a 50% duty cycle. A marker output, `sync_out`, goes high one period of the faster of banks A and C ahead of each instant where their rising edges line up, and falls exactly at that shared edge. Logic that works across both clock rates can use it as a baseline strobe.

Every individual output can be parked low through a parallel stop mask. A stop or restart only takes effect while the output is low, so no shortened pulse ever reaches a pin. One bank, chosen by a parameter, can be driven in antiphase to the others. A static bypass input swaps the divider clock from the fast source to a reference clock for test. Any change of a divider code, the post-divide input or the inversion input restarts every counter together, so the banks stay phase aligned.

Top module: `tri_bank_clkdiv`

## Requirements
- R1: Bank A codes 00, 01, 10, 11 give divisors 4, 6, 8, 12. Each q_a output has that period in divider-clock cycles.
- R2: Bank B codes 00, 01, 10, 11 give divisors 4, 6, 8, 10.
- R3: Bank C codes 00, 01, 10, 11 give divisors 2, 4, 6, 8.
- R4: When post_div2 is 1, every bank divisor is twice the value its code gives in R1 to R3.
- R5: Each output is high for exactly half its period.
- R6: sync_out has the least common multiple of the A and C divisors as its period. It is high for the smaller of the two divisors, and it falls in the same cycle where q_a and q_c both rise.
- R7: While rst_n is low, all outputs are low. On the first divider-clock edge after release, every running output of A, B and C rises together.
- R8: An output whose stop_mask bit is 1 stays low. The other outputs keep running. Bit i maps to q_a[i], bit NUM_A+i to q_b[i], and bit NUM_A+NUM_B+i to q_c[i].
- R9: Setting or clearing a stop bit never yields a high pulse shorter or longer than half the period.
- R10: With invert_en set, the inverted bank (B by default) is the complement of a bank with the same divisor.
- R11: With bypass_en set, the dividers count ref_clk edges instead of src_clk edges.
- R12: A change of sel_a, sel_b, sel_c, post_div2 or invert_en restarts all counters. On the next edge, every non-inverted, non-stopped output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast source clock |
| ref_clk | input | 1 | Reference clock used in bypass |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass_en | input | 1 | Selects ref_clk as the divider clock (static) |
| post_div2 | input | 1 | Doubles every divisor |
| sel_a | input | 2 | Bank A divisor code |
| sel_b | input | 2 | Bank B divisor code |
| sel_c | input | 2 | Bank C divisor code |
| invert_en | input | 1 | Antiphase for the parameter-chosen bank |
| stop_mask | input | NUM_A+NUM_B+NUM_C | Per-output stop request |
| q_a | output | NUM_A | Bank A clocks |
| q_b | output | NUM_B | Bank B clocks |
| q_c | output | NUM_C | Bank C clocks |
| sync_out | output | 1 | A/C coincidence marker |

## Verification
The bench uses the default parameters: four outputs per bank, bank B as the invertible bank, and a reference clock at one third of the source rate. With these values, the largest divisor (24) and the longest coincidence span (48 cycles) settle within a few hundred cycles. This lets the bench sweep every code of all three banks, under both post-divide settings. The bypass ratio of three makes a bypass period distinguishable from a normal one in source cycles.

// File: rtl/tbc_pkg.sv
// Package: shared widths, bank identifiers and divisor arithmetic for the
// three-bank divider. Assumes no divisor or coincidence span exceeds 63.
package tbc_pkg;

    localparam int DIV_W   = 6;   // width of every divider and span counter
    localparam int MAX_C   = 16;  // largest bank C divisor, bounds the span search

    typedef logic [DIV_W-1:0] div_t;

    typedef enum logic [1:0] {
        BANK_A = 2'd0,
        BANK_B = 2'd1,
        BANK_C = 2'd2
    } bank_e;

    // Divisor for one bank from its code, doubled when x2 is set.
    function automatic div_t bank_divisor(bank_e bank, logic [1:0] code, logic x2);
        div_t base;
        case (bank)
            BANK_A: begin
                case (code)
                    2'd0:    base = div_t'(4);
                    2'd1:    base = div_t'(6);
                    2'd2:    base = div_t'(8);
                    default: base = div_t'(12);
                endcase
            end
            BANK_B: begin
                case (code)
                    2'd0:    base = div_t'(4);
                    2'd1:    base = div_t'(6);
                    2'd2:    base = div_t'(8);
                    default: base = div_t'(10);
                endcase
            end
            default: begin
                case (code)
                    2'd0:    base = div_t'(2);
                    2'd1:    base = div_t'(4);
                    2'd2:    base = div_t'(6);
                    default: base = div_t'(8);
                endcase
            end
        endcase
        return x2 ? {base[DIV_W-2:0], 1'b0} : base;
    endfunction

    // Smallest multiple of a that c divides, i.e. the A/C coincidence span.
    function automatic div_t coincide_period(div_t a, div_t c);
        div_t res;
        logic found;
        int   prod;
        res   = a;
        found = 1'b0;
        for (int k = 1; k <= MAX_C; k++) begin
            prod = int'(a) * k;
            if (!found && (prod % int'(c)) == 0) begin
                res   = div_t'(prod);
                found = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/tbc_src_select.sv
// Module: picks the divider clock. Assumes bypass is static or changed only
// while reset is held, since this is a plain clock mux with no glitch guard.
module tbc_src_select (
    input  logic vco_clk,
    input  logic ref_clk,
    input  logic bypass,
    output logic div_clk
);

    // Route the reference straight to the dividers when bypassed.
    assign div_clk = bypass ? ref_clk : vco_clk;

endmodule

// File: rtl/tbc_bank_counter.sv
// Module: modulo-N phase counter for one bank. Produces the bank level for
// the current count and for the next count. Assumes an even divisor >= 2.
// Reset parks the count at N-1, so the first edge after reset is a rising edge.
module tbc_bank_counter
    import tbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic resync,
    input  div_t divisor,
    output logic level,
    output logic level_next
);

    div_t cnt;
    div_t cnt_next;
    div_t half;

    assign half = divisor >> 1;

    // Next count: restart on resync, wrap at the terminal count.
    always_comb begin
        if (resync) begin
            cnt_next = '0;
        end else if (cnt >= divisor - div_t'(1)) begin
            cnt_next = '0;
        end else begin
            cnt_next = cnt + div_t'(1);
        end
    end

    // Count register, parked one step before a rising edge in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= divisor - div_t'(1);
        end else begin
            cnt <= cnt_next;
        end
    end

    assign level      = (cnt < half);
    assign level_next = (cnt_next < half);

endmodule

// File: rtl/tbc_sync_tracker.sv
// Module: counts the A/C coincidence span and raises the marker during the
// last fast-bank period before each shared rising edge. Assumes it is reset
// and resynced together with the bank counters.
module tbc_sync_tracker
    import tbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic resync,
    input  div_t div_a,
    input  div_t div_c,
    output logic sync_q
);

    div_t span;
    div_t fast;
    div_t thresh;
    div_t cnt;
    div_t cnt_next;

    assign span   = coincide_period(div_a, div_c);
    assign fast   = (div_a < div_c) ? div_a : div_c;
    assign thresh = span - fast;

    // Next span position, aligned with the bank counters.
    always_comb begin
        if (resync) begin
            cnt_next = '0;
        end else if (cnt >= span - div_t'(1)) begin
            cnt_next = '0;
        end else begin
            cnt_next = cnt + div_t'(1);
        end
    end

    // Span counter and registered marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= span - div_t'(1);
            sync_q <= 1'b0;
        end else begin
            cnt    <= cnt_next;
            sync_q <= (cnt_next >= thresh);
        end
    end

endmodule

// File: rtl/tbc_stop_gate.sv
// Module: registered output stage for one pin with a glitch-free stop. The
// stop request is taken into the gate only when the pin will be low, so no
// pulse is ever cut short or stretched.
module tbc_stop_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic level_next,
    input  logic stop_req,
    output logic q
);

    logic gate;

    // Gate update while the pin is low, registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= stop_req;
            q    <= 1'b0;
        end else begin
            gate <= level_next ? gate : stop_req;
            q    <= level_next & ~gate;
        end
    end

endmodule

// File: rtl/tri_bank_clkdiv.sv
// Module: top of the three-bank divider. Selects the divider clock, watches
// the configuration for changes, runs one counter per bank and a span tracker,
// and drives every output pin through its own stop gate. Assumes the
// configuration inputs are synchronous to the divider clock.
module tri_bank_clkdiv
    import tbc_pkg::*;
#(
    parameter int    NUM_A    = 4,
    parameter int    NUM_B    = 4,
    parameter int    NUM_C    = 4,
    parameter bank_e INV_BANK = BANK_B
) (
    input  logic                         src_clk,
    input  logic                         ref_clk,
    input  logic                         rst_n,
    input  logic                         bypass_en,
    input  logic                         post_div2,
    input  logic [1:0]                   sel_a,
    input  logic [1:0]                   sel_b,
    input  logic [1:0]                   sel_c,
    input  logic                         invert_en,
    input  logic [NUM_A+NUM_B+NUM_C-1:0] stop_mask,
    output logic [NUM_A-1:0]             q_a,
    output logic [NUM_B-1:0]             q_b,
    output logic [NUM_C-1:0]             q_c,
    output logic                         sync_out
);

    localparam int NUM_BANKS = 3;
    localparam int OFF_B     = NUM_A;
    localparam int OFF_C     = NUM_A + NUM_B;
    localparam int CFG_W     = 8;

    logic             div_clk;
    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;
    logic             resync_w;
    div_t             div_arr [NUM_BANKS];
    logic [NUM_BANKS-1:0] lvl;
    logic [NUM_BANKS-1:0] lvl_nx;
    logic [NUM_BANKS-1:0] lvl_eff;
    logic             raw_a_w;
    logic             raw_b_w;
    logic             raw_c_w;

    tbc_src_select u_src (
        .vco_clk (src_clk),
        .ref_clk (ref_clk),
        .bypass  (bypass_en),
        .div_clk (div_clk)
    );

    assign cfg_now = {post_div2, sel_a, sel_b, sel_c, invert_en};

    // Remember the last configuration to detect changes.
    always_ff @(posedge div_clk) begin
        cfg_q <= cfg_now;
    end

    assign resync_w = rst_n && (cfg_now != cfg_q);

    // Divisor of each bank from its code and the post-divide input.
    always_comb begin
        div_arr[0] = bank_divisor(BANK_A, sel_a, post_div2);
        div_arr[1] = bank_divisor(BANK_B, sel_b, post_div2);
        div_arr[2] = bank_divisor(BANK_C, sel_c, post_div2);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        tbc_bank_counter u_cnt (
            .clk        (div_clk),
            .rst_n      (rst_n),
            .resync     (resync_w),
            .divisor    (div_arr[b]),
            .level      (lvl[b]),
            .level_next (lvl_nx[b])
        );
        if (b == int'(INV_BANK)) begin : g_inv
            assign lvl_eff[b] = lvl_nx[b] ^ invert_en;
        end else begin : g_plain
            assign lvl_eff[b] = lvl_nx[b];
        end
    end

    assign raw_a_w = lvl[0];
    assign raw_b_w = lvl[1];
    assign raw_c_w = lvl[2];

    tbc_sync_tracker u_sync (
        .clk    (div_clk),
        .rst_n  (rst_n),
        .resync (resync_w),
        .div_a  (div_arr[0]),
        .div_c  (div_arr[2]),
        .sync_q (sync_out)
    );

    for (genvar i = 0; i < NUM_A; i++) begin : g_out_a
        tbc_stop_gate u_gate (
            .clk        (div_clk),
            .rst_n      (rst_n),
            .level_next (lvl_eff[0]),
            .stop_req   (stop_mask[i]),
            .q          (q_a[i])
        );
    end

    for (genvar i = 0; i < NUM_B; i++) begin : g_out_b
        tbc_stop_gate u_gate (
            .clk        (div_clk),
            .rst_n      (rst_n),
            .level_next (lvl_eff[1]),
            .stop_req   (stop_mask[OFF_B+i]),
            .q          (q_b[i])
        );
    end

    for (genvar i = 0; i < NUM_C; i++) begin : g_out_c
        tbc_stop_gate u_gate (
            .clk        (div_clk),
            .rst_n      (rst_n),
            .level_next (lvl_eff[2]),
            .stop_req   (stop_mask[OFF_C+i]),
            .q          (q_c[i])
        );
    end

endmodule

// File: rtl/tri_bank_clkdiv_chk.sv
// Checker: temporal properties of the three-bank divider, bound to the top.
// Samples on the divider clock, so it follows bypass as well.
module tri_bank_clkdiv_chk #(
    parameter int NUM_A = 4,
    parameter int NUM_B = 4,
    parameter int NUM_C = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NUM_A-1:0] stop_a,
    input logic [NUM_A-1:0] q_a,
    input logic [NUM_B-1:0] q_b,
    input logic [NUM_C-1:0] q_c,
    input logic             sync_out,
    input logic             raw_a,
    input logic             raw_b,
    input logic             raw_c,
    input logic             resync
);

    // R7
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (q_a == '0 && q_b == '0 && q_c == '0 && !sync_out));

    for (genvar i = 0; i < NUM_A; i++) begin : g_stop
        // R8
        stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_a[i] && $past(stop_a[i]) && !q_a[i]) |=> !q_a[i]);
    end

    // R6
    sync_coinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_out) && !$past(resync)) |-> ($rose(raw_a) && $rose(raw_c)));

    // R12
    resync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (raw_a && raw_b && raw_c));

endmodule

bind tri_bank_clkdiv tri_bank_clkdiv_chk #(
    .NUM_A (NUM_A),
    .NUM_B (NUM_B),
    .NUM_C (NUM_C)
) u_chk (
    .clk      (div_clk),
    .rst_n    (rst_n),
    .stop_a   (stop_mask[NUM_A-1:0]),
    .q_a      (q_a),
    .q_b      (q_b),
    .q_c      (q_c),
    .sync_out (sync_out),
    .raw_a    (raw_a_w),
    .raw_b    (raw_b_w),
    .raw_c    (raw_c_w),
    .resync   (resync_w)
);

// File: tb/tri_bank_clkdiv_bench.sv
// Bench: vector sweep of divisor codes, then directed reset, stop, resync,
// inversion and bypass tests. Outputs are sampled on the source falling edge.
module tri_bank_clkdiv_bench;

    localparam int CLK_PERIOD = 10;
    localparam int REF_RATIO  = 3;
    localparam int NA = 4;
    localparam int NB = 4;
    localparam int NC = 4;
    localparam int NV = 6;

    typedef struct packed {
        logic       p2;
        logic [1:0] sa;
        logic [1:0] sb;
        logic [1:0] sc;
        int         a;
        int         b;
        int         c;
        int         l;
        int         f;
    } vec_t;

    // code sets and expected A/B/C periods, coincidence span, marker width
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 2'd0, 2'd0,  4,  4,  2,  4,  2},
        '{1'b0, 2'd1, 2'd1, 2'd1,  6,  6,  4, 12,  4},
        '{1'b0, 2'd3, 2'd3, 2'd3, 12, 10,  8, 24,  8},
        '{1'b1, 2'd2, 2'd2, 2'd2, 16, 16, 12, 48, 12},
        '{1'b1, 2'd3, 2'd3, 2'd0, 24, 20,  4, 24,  4},
        '{1'b0, 2'd2, 2'd3, 2'd2,  8, 10,  6, 24,  6}
    };

    logic src_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic bypass_en = 1'b0;
    logic post_div2 = 1'b0;
    logic invert_en = 1'b0;
    logic [1:0] sel_a = 2'd0;
    logic [1:0] sel_b = 2'd0;
    logic [1:0] sel_c = 2'd0;
    logic [NA+NB+NC-1:0] stop_mask = '0;
    logic [NA-1:0] q_a;
    logic [NB-1:0] q_b;
    logic [NC-1:0] q_c;
    logic sync_out;

    always #(CLK_PERIOD/2) src_clk = ~src_clk;
    always #(CLK_PERIOD*REF_RATIO/2) ref_clk = ~ref_clk;

    tri_bank_clkdiv u_tri_bank_clkdiv (
        .src_clk   (src_clk),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .bypass_en (bypass_en),
        .post_div2 (post_div2),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .sel_c     (sel_c),
        .invert_en (invert_en),
        .stop_mask (stop_mask),
        .q_a       (q_a),
        .q_b       (q_b),
        .q_c       (q_c),
        .sync_out  (sync_out)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: 0=q_a[0] 1=q_b[0] 2=q_c[0] 3=sync_out 4=q_a[1]
    int cyc = 0;
    int last_rise [5] = '{default: 0};
    int period    [5] = '{default: 0};
    int hwidth    [5] = '{default: 0};
    int rises     [5] = '{default: 0};
    logic [4:0] prev_s = '0;
    int coinc_bad = 0;
    int runts = 0;
    bit runt_watch = 1'b0;
    int exp_half_watch = 0;

    always @(negedge src_clk) begin
        logic [4:0] cur;
        cur = {q_a[1], sync_out, q_c[0], q_b[0], q_a[0]};
        cyc++;
        for (int i = 0; i < 5; i++) begin
            if (cur[i] && !prev_s[i]) begin
                period[i]    = cyc - last_rise[i];
                last_rise[i] = cyc;
                rises[i]++;
            end
            if (!cur[i] && prev_s[i]) begin
                hwidth[i] = cyc - last_rise[i];
                if (i == 4 && runt_watch && hwidth[i] != exp_half_watch) runts++;
            end
        end
        if (prev_s[3] && !cur[3] &&
            !(cur[0] && !prev_s[0] && cur[2] && !prev_s[2])) coinc_bad++;
        prev_s = cur;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge src_clk);
    endtask

    task automatic apply_cfg(input logic p2, input logic [1:0] sa,
                             input logic [1:0] sb, input logic [1:0] sc);
        @(negedge src_clk);
        post_div2 = p2;
        sel_a = sa;
        sel_b = sb;
        sel_c = sc;
    endtask

    initial begin
        int snap_stop;
        int snap_run;
        int mism;
        // R7 reset state
        wait_cyc(4);
        check(q_a == '0, "R7 reset q_a", int'(q_a), 0);
        check(q_b == '0, "R7 reset q_b", int'(q_b), 0);
        check(q_c == '0, "R7 reset q_c", int'(q_c), 0);
        check(sync_out == 1'b0, "R7 reset sync_out", int'(sync_out), 0);
        rst_n = 1'b1;
        @(negedge src_clk);
        check(q_a == '1 && q_b == '1 && q_c == '1, "R7 aligned first rise",
              int'({q_a, q_b, q_c}), 4095);

        // vector sweep: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            apply_cfg(VECS[v].p2, VECS[v].sa, VECS[v].sb, VECS[v].sc);
            wait_cyc(60);
            coinc_bad = 0;
            wait_cyc(100);
            check(period[0] == VECS[v].a, VECS[v].p2 ? "R1 R4 bank A period" : "R1 bank A period",
                  period[0], VECS[v].a);
            check(period[1] == VECS[v].b, VECS[v].p2 ? "R2 R4 bank B period" : "R2 bank B period",
                  period[1], VECS[v].b);
            check(period[2] == VECS[v].c, VECS[v].p2 ? "R3 R4 bank C period" : "R3 bank C period",
                  period[2], VECS[v].c);
            check(hwidth[0] == VECS[v].a / 2, "R5 bank A high time", hwidth[0], VECS[v].a / 2);
            check(hwidth[1] == VECS[v].b / 2, "R5 bank B high time", hwidth[1], VECS[v].b / 2);
            check(hwidth[2] == VECS[v].c / 2, "R5 bank C high time", hwidth[2], VECS[v].c / 2);
            check(period[3] == VECS[v].l, "R6 sync period", period[3], VECS[v].l);
            check(hwidth[3] == VECS[v].f, "R6 sync high time", hwidth[3], VECS[v].f);
            check(coinc_bad == 0, "R6 sync fall at shared edge", coinc_bad, 0);
        end

        // R8 and R9: stop q_a[1] mid-pulse, then restart at an arbitrary phase
        apply_cfg(1'b0, 2'd3, 2'd3, 2'd2);
        wait_cyc(60);
        exp_half_watch = 6;
        runts = 0;
        runt_watch = 1'b1;
        do @(negedge src_clk); while (!q_a[1]);
        wait_cyc(2);
        stop_mask[1] = 1'b1;
        wait_cyc(30);
        snap_stop = rises[4];
        snap_run  = rises[0];
        wait_cyc(36);
        check(rises[4] == snap_stop, "R8 stopped output has no rise", rises[4] - snap_stop, 0);
        check(q_a[1] == 1'b0, "R8 stopped output low", int'(q_a[1]), 0);
        check(rises[0] - snap_run == 3, "R8 neighbour keeps running", rises[0] - snap_run, 3);
        wait_cyc(5);
        stop_mask[1] = 1'b0;
        wait_cyc(40);
        runt_watch = 1'b0;
        check(runts == 0, "R9 no runt pulse on stop or restart", runts, 0);
        check(period[4] == 12, "R9 restarted output period", period[4], 12);

        // R12: change bank A code while q_a[0] has just gone low
        do @(negedge src_clk); while (!q_a[0]);
        do @(negedge src_clk); while (q_a[0]);
        sel_a = 2'd0;
        @(negedge src_clk);
        check(q_a[0] && q_b[0] && q_c[0], "R12 banks restart together",
              int'({q_a[0], q_b[0], q_c[0]}), 7);
        wait_cyc(40);
        check(period[0] == 4, "R12 R1 new bank A period", period[0], 4);

        // R10: bank B inverted against bank A at equal divisors
        @(negedge src_clk);
        sel_a = 2'd0;
        sel_b = 2'd0;
        sel_c = 2'd0;
        post_div2 = 1'b0;
        invert_en = 1'b1;
        wait_cyc(20);
        mism = 0;
        repeat (16) begin
            @(negedge src_clk);
            if (q_b[0] !== ~q_a[0]) mism++;
        end
        check(mism == 0, "R10 bank B antiphase to bank A", mism, 0);
        check(period[1] == 4, "R10 inverted bank period", period[1], 4);
        @(negedge src_clk);
        invert_en = 1'b0;

        // R11: bypass onto the reference clock
        rst_n = 1'b0;
        wait_cyc(2);
        bypass_en = 1'b1;
        wait_cyc(12);
        rst_n = 1'b1;
        wait_cyc(150);
        check(period[0] == 4 * REF_RATIO, "R11 bypass bank A period", period[0], 4 * REF_RATIO);
        check(period[2] == 2 * REF_RATIO, "R11 bypass bank C period", period[2], 2 * REF_RATIO);
        check(hwidth[0] == 2 * REF_RATIO, "R11 bypass bank A high time", hwidth[0], 2 * REF_RATIO);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule